// File: doc/BRIEF.md
# Serial peripheral shift master with phase-aware chip select

This block is the shift engine of a serial peripheral master. Its clock idles high. It moves 8-bit words most-significant bit first, on two data lines at once. A byte is handed over with a one-cycle write strobe. The engine then asserts a chip-select line whose active level is programmable, and waits half a serial-clock period. After that it runs sixteen serial-clock edges, waits another half period, and returns the received byte with a one-cycle completion strobe.

Either clock phase can be used. In phase 0, data is set up before the first falling edge and sampled on falling edges. Every frame is bracketed by its own select pulse. In phase 1, data moves on falling edges and is sampled on rising edges. A byte written while a frame is running is held in a one-entry slot and sent within the same select window. The serial-clock half period is a whole number of system clocks, set by a divider input. The divider, the phase and the select polarity are captured when a frame starts.

Top module: `spim_master`

## Requirements
- R1: `sck` is 1 whenever `busy` is 0. `busy` rises in the cycle after an accepted write and falls in the same cycle as the last `rx_done` pulse.
- R2: A frame is 8 bits, MSB first on both `mosi` and `miso`. The received byte appears on `rx_data` in the same cycle as a one-cycle `rx_done` pulse, and each frame gives exactly one pulse.
- R3: With `cfg_cpha`=1, `mosi` changes only when `sck` falls, and `miso` is taken on the rising edge of `sck`.
- R4: With `cfg_cpha`=0, `mosi` changes only when `sck` rises, and `miso` is taken on the falling edge of `sck`.
- R5: The first data bit is on `mosi` in the cycle after the write is accepted, while `sck` is still high.
- R6: The select is active at the level of `cfg_sel_hi`: 0 means active low, 1 means active high. While the block is idle, `sel` shows the inactive level of the live `cfg_sel_hi`.
- R7: Each `sck` half period lasts `cfg_div`+1 clocks. The gap from select assertion to the first falling `sck` edge is also `cfg_div`+1 clocks, and so is the gap from the last rising edge to select release. Each frame has exactly 8 falling `sck` edges.
- R8: With `cfg_cpha`=0, writes while `busy` is 1 are ignored. The select returns to inactive after every frame, for at least one clock, before a new frame starts.
- R9: With `cfg_cpha`=1, one write made while `busy` is 1 is queued and sent in the same select window. Further writes while the slot is full are ignored, as is a write in the cycle that finishes a frame. The select is released only after the last frame.
- R10: `cfg_div`, `cfg_cpha` and `cfg_sel_hi` are captured only when a frame starts from idle. Changing them while `busy` is 1 has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Half-period divider; the half period is cfg_div+1 clocks |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_sel_hi | input | 1 | Select polarity; 1 means active high |
| tx_data | input | FRAME_W | Byte to send |
| tx_valid | input | 1 | Write strobe for tx_data |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Frame or burst in progress |
| rx_data | output | FRAME_W | Last received byte |
| rx_done | output | 1 | One-cycle strobe when a frame finishes |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the peripheral |
| sel | output | 1 | Chip select |

## Verification
The hardest case to reach is a second byte that lands in the holding slot while the phase-1 frame before it is still shifting. It takes a write at exactly the right moment in the middle of a frame. A third write must also arrive while the slot is full, to show that it is dropped. The bench issues these writes a fixed number of cycles after the first one. A peripheral model replies with a new byte after every eighth sample. The bench then counts select releases, completion strobes and the bytes the model captured. A similar mid-frame write in phase 0, and configuration changes during a frame, cover the other paths where input must be ignored.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } spim_state_t;
endpackage

// File: rtl/spim_tick.sv
// Half-period timer: pulses tick every div+1 clocks while run is high.
module spim_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spim_shreg.sv
// Transmit and receive shift registers, MSB first.
module spim_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         sample_en,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] sh_tx;
  logic [W-1:0] sh_rx;

  assign mosi    = sh_tx[W-1];
  assign rx_word = sh_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_tx <= '0;
      sh_rx <= '0;
    end else begin
      if (load) sh_tx <= load_val;
      else if (shift_en) sh_tx <= {sh_tx[W-2:0], 1'b0};
      if (sample_en) sh_rx <= {sh_rx[W-2:0], miso};
    end
  end
endmodule

// File: rtl/spim_master.sv
module spim_master #(
  parameter int DIV_W   = 8,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               cfg_cpha,
  input  logic               cfg_sel_hi,
  input  logic [FRAME_W-1:0] tx_data,
  input  logic               tx_valid,
  input  logic               miso,
  output logic               busy,
  output logic [FRAME_W-1:0] rx_data,
  output logic               rx_done,
  output logic               sck,
  output logic               mosi,
  output logic               sel
);
  import spim_pkg::*;

  localparam int EDGES = 2 * FRAME_W;
  localparam int EW    = $clog2(EDGES + 1);
  localparam logic [EW-1:0] EDGE_FIRST = EW'(1);
  localparam logic [EW-1:0] EDGE_LAST  = EW'(EDGES);

  spim_state_t        st;
  logic               cpha_q;
  logic               selhi_q;
  logic [DIV_W-1:0]   div_q;
  logic [EW-1:0]      edge_q;
  logic               pend_vld;
  logic [FRAME_W-1:0] pend_data;
  logic [FRAME_W-1:0] rx_sh;

  logic               tick;
  logic               lead_tick, edge_evt, tail_done;
  logic [EW-1:0]      edge_nx, cur_edge;
  logic               odd_edge, sample_en, shift_en;
  logic               start, cont, load, take_pend;
  logic [FRAME_W-1:0] load_val;

  spim_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (st != ST_IDLE),
    .div  (div_q),
    .tick (tick)
  );

  always_comb begin
    edge_nx   = edge_q + 1'b1;
    lead_tick = (st == ST_LEAD) && tick;
    edge_evt  = lead_tick || ((st == ST_SHIFT) && tick);
    cur_edge  = lead_tick ? EDGE_FIRST : edge_nx;
    odd_edge  = cur_edge[0];
    // Falling edges are odd, rising edges even (clock idles high).
    sample_en = edge_evt && (cpha_q ? !odd_edge : odd_edge);
    shift_en  = edge_evt && (cpha_q ? (odd_edge && cur_edge != EDGE_FIRST)
                                    : (!odd_edge && cur_edge != EDGE_LAST));
    tail_done = (st == ST_TAIL) && tick;
    start     = (st == ST_IDLE) && tx_valid;
    cont      = tail_done && cpha_q && pend_vld;
    load      = start || cont;
    load_val  = start ? tx_data : pend_data;
    take_pend = tx_valid && (st != ST_IDLE) && cpha_q && !pend_vld && !tail_done;
  end

  spim_shreg #(.W(FRAME_W)) u_shreg (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_val  (load_val),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_sh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sck       <= 1'b1;
      sel       <= 1'b1;
      busy      <= 1'b0;
      rx_done   <= 1'b0;
      rx_data   <= '0;
      cpha_q    <= 1'b0;
      selhi_q   <= 1'b0;
      div_q     <= '0;
      edge_q    <= '0;
      pend_vld  <= 1'b0;
      pend_data <= '0;
    end else begin
      rx_done <= 1'b0;
      if (take_pend) begin
        pend_vld  <= 1'b1;
        pend_data <= tx_data;
      end
      case (st)
        ST_IDLE: begin
          sck <= 1'b1;
          sel <= ~cfg_sel_hi;
          if (tx_valid) begin
            cpha_q  <= cfg_cpha;
            selhi_q <= cfg_sel_hi;
            div_q   <= cfg_div;
            sel     <= cfg_sel_hi;
            busy    <= 1'b1;
            st      <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            sck    <= 1'b0;
            edge_q <= EDGE_FIRST;
            st     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck    <= ~sck;
            edge_q <= edge_nx;
            if (edge_nx == EDGE_LAST) st <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            rx_data <= rx_sh;
            rx_done <= 1'b1;
            if (cpha_q && pend_vld) begin
              pend_vld <= 1'b0;
              st       <= ST_LEAD;
            end else begin
              busy <= 1'b0;
              sel  <= ~selhi_q;
              st   <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic sck,
  input logic sel,
  input logic mosi,
  input logic rx_done,
  input logic cfg_sel_hi,
  input logic cpha_q,
  input logic selhi_q
);
  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && cpha_q && $rose(sck)) |-> $stable(mosi));

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !cpha_q && $fell(sck)) |-> $stable(mosi));

  assert_sel_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(rst)) |-> (sel == !$past(cfg_sel_hi)));

  assert_sck_in_select_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck) |-> (busy && sel == selhi_q));
endmodule

bind spim_master spim_master_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .sck        (sck),
  .sel        (sel),
  .mosi       (mosi),
  .rx_done    (rx_done),
  .cfg_sel_hi (cfg_sel_hi),
  .cpha_q     (cpha_q),
  .selhi_q    (selhi_q)
);

// File: tb/tb_spim_master.sv
`timescale 1ns/1ps
module tb_spim_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_div = 8'd0;
  logic       cfg_cpha = 1'b0;
  logic       cfg_sel_hi = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0;
  logic       miso = 1'b0;
  logic       busy, rx_done, sck, mosi, sel;
  logic [7:0] rx_data;

  always #5 clk = ~clk;

  spim_master #(.DIV_W(8), .FRAME_W(8)) dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_cpha(cfg_cpha),
    .cfg_sel_hi(cfg_sel_hi), .tx_data(tx_data), .tx_valid(tx_valid),
    .miso(miso), .busy(busy), .rx_data(rx_data), .rx_done(rx_done),
    .sck(sck), .mosi(mosi), .sel(sel)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Peripheral model
  logic       s_cpha = 1'b0;
  logic       s_pol = 1'b0;
  logic [7:0] sl_q [4];
  int         sl_idx = 0;
  logic [7:0] s_tx = 8'd0, s_rx = 8'd0;
  int         s_ns = 0;
  logic [7:0] cap_q [8];
  int         cap_n = 0;

  always @(sel) begin
    if (!rst && sel == s_pol) begin
      sl_idx = 0;
      s_tx = sl_q[0];
      miso = s_tx[7];
      s_ns = 0;
    end
  end

  always @(negedge sck) begin
    if (!rst && sel == s_pol) begin
      if (!s_cpha) begin
        s_rx = {s_rx[6:0], mosi};
        s_ns++;
        if (s_ns % 8 == 0) begin cap_q[cap_n % 8] = s_rx; cap_n++; end
      end else if (s_ns % 8 != 0) begin
        s_tx = {s_tx[6:0], 1'b0};
        miso = s_tx[7];
      end
    end
  end

  always @(posedge sck) begin
    if (!rst && sel == s_pol) begin
      if (s_cpha) begin
        s_rx = {s_rx[6:0], mosi};
        s_ns++;
        if (s_ns % 8 == 0) begin
          cap_q[cap_n % 8] = s_rx;
          cap_n++;
          sl_idx++;
          s_tx = sl_q[sl_idx % 4];
          miso = s_tx[7];
        end
      end else if (s_ns % 8 != 0) begin
        s_tx = {s_tx[6:0], 1'b0};
        miso = s_tx[7];
      end
    end
  end

  // Timing monitor
  int cyc = 0, t_sel = 0, t_f1 = 0, t_r1 = 0, t_rlast = 0, t_off = 0;
  int n_fall = 0, n_rise = 0, on_cnt = 0, off_cnt = 0, done_cnt = 0;
  logic [7:0] rxlog [4];
  logic p_act = 1'b0, p_sck = 1'b1;

  always @(posedge clk) begin
    logic act;
    act = (sel == s_pol);
    if (!rst) begin
      if (act && !p_act) begin t_sel = cyc; n_fall = 0; n_rise = 0; on_cnt++; end
      if (!act && p_act) begin t_off = cyc; off_cnt++; end
      if (p_sck && !sck) begin if (n_fall == 0) t_f1 = cyc; n_fall++; end
      if (!p_sck && sck) begin if (n_rise == 0) t_r1 = cyc; n_rise++; t_rlast = cyc; end
      if (rx_done) begin rxlog[done_cnt % 4] = rx_data; done_cnt++; end
    end
    p_act = act;
    p_sck = sck;
    cyc++;
  end

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle;
    int g = 0;
    while (busy && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic set_cfg(input logic ph, input logic pol, input logic [7:0] dv);
    @(negedge clk);
    cfg_cpha = ph; cfg_sel_hi = pol; cfg_div = dv;
    s_cpha = ph; s_pol = pol;
  endtask

  // {cpha, pol, div, tx, peripheral byte}
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b0, 8'd1, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 8'd0, 8'h81, 8'h7E},
    {1'b0, 1'b1, 8'd3, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 8'd2, 8'hFF, 8'h00},
    {1'b0, 1'b0, 8'd0, 8'h00, 8'hFF},
    {1'b1, 1'b0, 8'd5, 8'h96, 8'h69}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bd, bc, bo, bn;
    for (int i = 0; i < 4; i++) sl_q[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1, R6: reset and idle state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(sck == 1'b1, "R1 sck idle high", sck, 1);
    chk(rx_done == 1'b0, "R2 no done after reset", rx_done, 0);
    chk(sel == 1'b1, "R6 idle sel inactive-high for active-low", sel, 1);
    cfg_sel_hi = 1'b1; s_pol = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(sel == 1'b0, "R6 idle sel follows live polarity", sel, 0);

    // Vector table
    for (int v = 0; v < 6; v++) begin
      logic [25:0] e;
      int h;
      e = VEC[v];
      h = int'(e[23:16]) + 1;
      set_cfg(e[25], e[24], e[23:16]);
      sl_q[0] = e[7:0];
      @(negedge clk);
      bd = done_cnt; bc = cap_n;
      write_byte(e[15:8]);
      chk(busy == 1'b1, "R1 busy after write", busy, 1);
      wait_idle();
      @(negedge clk);
      chk(done_cnt - bd == 1, "R2 one done per frame", done_cnt - bd, 1);
      chk(rxlog[bd % 4] == e[7:0], e[25] ? "R3 rx byte" : "R4 rx byte", rxlog[bd % 4], e[7:0]);
      chk(cap_n - bc == 1 && cap_q[bc % 8] == e[15:8], e[25] ? "R3 mosi byte" : "R4 mosi byte",
          cap_q[bc % 8], e[15:8]);
      chk(t_f1 - t_sel == h, "R7 lead gap", t_f1 - t_sel, h);
      chk(t_r1 - t_f1 == h, "R7 half period", t_r1 - t_f1, h);
      chk(t_off - t_rlast == h, "R7 tail gap", t_off - t_rlast, h);
      chk(n_fall == 8, "R7 falling edge count", n_fall, 8);
      chk(sck == 1'b1 && busy == 1'b0, "R1 idle after frame", {busy, sck}, 1);
      chk(sel == ~e[24], "R6 sel inactive after frame", sel, ~e[24]);
    end

    // R5: first bit driven before any clock edge
    set_cfg(1'b1, 1'b0, 8'd4);
    sl_q[0] = 8'h11;
    write_byte(8'h80);
    chk(mosi == 1'b1 && sck == 1'b1, "R5 first bit at write", {mosi, sck}, 2'b11);
    chk(sel == 1'b0, "R6 active-low select asserted", sel, 0);
    wait_idle();
    @(negedge clk);

    // R8: write while busy ignored in phase 0
    set_cfg(1'b0, 1'b0, 8'd1);
    sl_q[0] = 8'h42;
    bd = done_cnt; bc = cap_n; bo = off_cnt;
    write_byte(8'h3C);
    repeat (10) @(negedge clk);
    write_byte(8'hFF);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(done_cnt - bd == 1, "R8 busy write ignored (done)", done_cnt - bd, 1);
    chk(cap_n - bc == 1 && cap_q[bc % 8] == 8'h3C, "R8 busy write ignored (data)", cap_q[bc % 8], 8'h3C);
    chk(busy == 1'b0, "R8 no second frame", busy, 0);

    // R8: back-to-back frames in phase 0 release select between them
    sl_q[0] = 8'h99;
    bd = done_cnt; bc = cap_n; bo = off_cnt; bn = on_cnt;
    write_byte(8'h6D);
    wait_idle();
    write_byte(8'hB2);
    wait_idle();
    @(negedge clk);
    chk(off_cnt - bo == 2 && on_cnt - bn == 2, "R8 select released between frames", off_cnt - bo, 2);
    chk(cap_q[bc % 8] == 8'h6D && cap_q[(bc + 1) % 8] == 8'hB2, "R8 both frames sent",
        cap_q[(bc + 1) % 8], 8'hB2);
    chk(done_cnt - bd == 2, "R8 two done pulses", done_cnt - bd, 2);

    // R9: phase-1 burst with one queued byte and one dropped write
    set_cfg(1'b1, 1'b0, 8'd1);
    sl_q[0] = 8'hA1; sl_q[1] = 8'h5B;
    bd = done_cnt; bc = cap_n; bo = off_cnt; bn = on_cnt;
    write_byte(8'hC7);
    repeat (5) @(negedge clk);
    write_byte(8'h18);
    repeat (5) @(negedge clk);
    write_byte(8'hEE);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(done_cnt - bd == 2, "R9 two frames in burst", done_cnt - bd, 2);
    chk(off_cnt - bo == 1 && on_cnt - bn == 1, "R9 select held across burst", off_cnt - bo, 1);
    chk(cap_n - bc == 2, "R9 third write dropped", cap_n - bc, 2);
    chk(cap_q[bc % 8] == 8'hC7 && cap_q[(bc + 1) % 8] == 8'h18, "R9 burst mosi bytes",
        cap_q[(bc + 1) % 8], 8'h18);
    chk(rxlog[bd % 4] == 8'hA1 && rxlog[(bd + 1) % 4] == 8'h5B, "R9 burst rx bytes",
        rxlog[(bd + 1) % 4], 8'h5B);

    // R10: configuration changes during a frame have no effect
    set_cfg(1'b0, 1'b0, 8'd2);
    sl_q[0] = 8'h27;
    bd = done_cnt; bc = cap_n;
    write_byte(8'hD4);
    cfg_div = 8'd0; cfg_cpha = 1'b1; cfg_sel_hi = 1'b1;
    repeat (8) @(negedge clk);
    chk(sel == 1'b0, "R10 polarity change ignored", sel, 0);
    repeat (10) @(negedge clk);
    cfg_div = 8'd2; cfg_cpha = 1'b0; cfg_sel_hi = 1'b0;
    wait_idle();
    @(negedge clk);
    chk(t_f1 - t_sel == 3 && t_r1 - t_f1 == 3, "R10 divider change ignored", t_r1 - t_f1, 3);
    chk(cap_q[bc % 8] == 8'hD4 && rxlog[bd % 4] == 8'h27, "R10 phase change ignored",
        rxlog[bd % 4], 8'h27);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule